// File: doc/BRIEF.md
# BIST Result Status Reporter

This block drives the three-bit result bus that a memory self-test controller presents to the tester. It takes four single-cycle events from the test engine: a failed compare, an address-counter expiry, a test-complete event and a run start. From them it produces three status bits: progress (bit 0), failure (bit 1) and done (bit 2). An instruction-supplied mode bit selects how failures are reported. In pulse mode there is one output pulse per failed compare. In sticky mode a single level is raised by the first failure and held until the next run.

The block has an active-low self-test reset and a test-enable input. In functional mode both are held low, and the result bus must then stay at zero. All outputs are registered from the inputs sampled at the previous rising clock edge. The exception is the test-enable gating, which acts in the same cycle.

Top module: `bist_result_reporter`

## Requirements
- R1: While `rst_n` is low, `result` is 3'b000, and all internal state is cleared.
- R2: While `test_en` is low, `result` is 3'b000 in the same cycle, and events sampled at such an edge are discarded. After `test_en` returns high, `result` stays 3'b000 until a new event is sampled.
- R3: `result[0]` is high for exactly the one cycle after each edge at which `expire` is sampled high, and is low otherwise.
- R4: When `pulse_mode` was 1 at the previous edge, `result[1]` equals the `fail` value sampled at that edge, giving one cycle per failed compare.
- R5: When `pulse_mode` was 0 at the previous edge, `result[1]` is high from the cycle after the first sampled `fail`. It stays high until a `start`, a reset or a test-enable drop.
- R6: `result[2]` goes high in the cycle after `done_evt` is sampled and holds until a `start`, a reset or a test-enable drop.
- R7: `start` clears the sticky fail and done state. A `fail` or `done_evt` sampled at the same edge as `start` belongs to the new run and is still recorded.
- R8: A `fail` sampled at the same edge as `done_evt` is reported on `result[1]` in the cycle in which `result[2]` rises, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Self-test reset, active low, asynchronous |
| test_en | input | 1 | Self-test path enable; low in functional mode |
| start | input | 1 | Single-cycle start of a new run |
| fail | input | 1 | Single-cycle failed compare |
| expire | input | 1 | Single-cycle address-counter expiry |
| done_evt | input | 1 | Single-cycle test-complete event |
| pulse_mode | input | 1 | Fail reporting mode: 1 pulse, 0 sticky |
| result | output | 3 | {done, fail, expire/progress} |

## Verification
The hardest situations to reach are the event collisions. These are a failure at the same edge as completion, a failure at the same edge as a new run's start, and a test-enable drop in the middle of a sticky run. Random traffic seldom lands these on a chosen edge. Directed steps therefore force each collision, in both fail modes. Seeded random runs follow, with the mode redrawn at every start, so that sticky state carries across many done events and enable drops.

// File: rtl/bist_result_reporter.sv
module bist_result_reporter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  input  logic       start,
  input  logic       fail,
  input  logic       expire,
  input  logic       done_evt,
  input  logic       pulse_mode,
  output logic [2:0] result
);

  logic mode_q, expire_q, fail_hit_q, fail_lvl_q, done_q;
  logic fail_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      expire_q   <= 1'b0;
      fail_hit_q <= 1'b0;
      fail_lvl_q <= 1'b0;
      done_q     <= 1'b0;
    end else if (!test_en) begin
      mode_q     <= 1'b0;
      expire_q   <= 1'b0;
      fail_hit_q <= 1'b0;
      fail_lvl_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      mode_q     <= pulse_mode;
      expire_q   <= expire;
      fail_hit_q <= fail;
      fail_lvl_q <= fail | (fail_lvl_q & ~start);
      done_q     <= done_evt | (done_q & ~start);
    end
  end

  assign fail_out = mode_q ? fail_hit_q : fail_lvl_q;
  assign result   = test_en ? {done_q, fail_out, expire_q} : 3'b000;

endmodule

module bist_result_reporter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_en,
  input logic       start,
  input logic       fail,
  input logic       expire,
  input logic       done_evt,
  input logic       pulse_mode,
  input logic [2:0] result
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> result == 3'b000);

  a_r2_enable_return_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(test_en) && test_en) |-> result == 3'b000);

  a_r3_expire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en) && test_en) |-> result[0] == $past(expire));

  a_r4_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en) && test_en && $past(pulse_mode)) |-> result[1] == $past(fail));

  a_r5_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en) && test_en && !$past(pulse_mode) && $past(fail)) |-> result[1]);

  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en) && test_en && ($past(done_evt) || ($past(result[2]) && !$past(start)))) |-> result[2]);

  a_r7_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en) && test_en && $past(start) && !$past(done_evt)) |-> !result[2]);

  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en) && test_en && $past(done_evt) && $past(fail)) |-> result[2:1] == 2'b11);

endmodule

bind bist_result_reporter bist_result_reporter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start), .fail(fail),
  .expire(expire), .done_evt(done_evt), .pulse_mode(pulse_mode), .result(result)
);

// File: tb/bist_result_reporter_bench.sv
module bist_result_reporter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, test_en, start, fail, expire, done_evt, pulse_mode;
  logic [2:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic m_mode, m_exp, m_hit, m_lvl, m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_result_reporter u_bist_result_reporter (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start), .fail(fail),
    .expire(expire), .done_evt(done_evt), .pulse_mode(pulse_mode), .result(result)
  );

  function automatic logic [2:0] exp_result(input logic te);
    if (!te) return 3'b000;
    return {m_done, (m_mode ? m_hit : m_lvl), m_exp};
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_mode = 0; m_exp = 0; m_hit = 0; m_lvl = 0; m_done = 0;
  endtask

  task automatic model_edge();
    if (!test_en) model_clear();
    else begin
      m_mode = pulse_mode;
      m_exp  = expire;
      m_hit  = fail;
      m_lvl  = fail | (m_lvl & ~start);
      m_done = done_evt | (m_done & ~start);
    end
  endtask

  task automatic check_bits();
    logic [2:0] e;
    e = exp_result(test_en);
    if (!test_en) check("R2 quiet", result, e);
    else begin
      check("R3 progress", {2'b0, result[0]}, {2'b0, e[0]});
      check(m_mode ? "R4 pulse fail" : "R5 sticky fail", {2'b0, result[1]}, {2'b0, e[1]});
      check("R6 done", {2'b0, result[2]}, {2'b0, e[2]});
    end
  endtask

  task automatic step(input logic te, input logic st, input logic f, input logic e,
                      input logic d, input logic pm);
    test_en = te; start = st; fail = f; expire = e; done_evt = d; pulse_mode = pm;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_bits();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; test_en = 1; start = 1; fail = 1; expire = 1; done_evt = 1; pulse_mode = 0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset", result, 3'b000);
    rst_n = 1;
    step(1, 0, 0, 0, 0, 0);
    check("R1 after release", result, 3'b000);

    // R5 sticky hold across idle cycles and a done
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0);
    check("R5 sticky after done", result, 3'b110);
    // R7 start clears, same-edge fail recorded
    step(1, 1, 1, 0, 0, 0);
    check("R7 start with fail", result, 3'b010);
    step(1, 1, 0, 0, 0, 0);
    check("R7 start clears", result, 3'b000);
    step(1, 1, 0, 0, 1, 0);
    check("R7 start with done", result, 3'b100);
    // R8 fail coincident with done, both modes
    step(1, 1, 0, 0, 0, 1);
    step(1, 0, 1, 0, 1, 1);
    check("R8 pulse mode", result, 3'b110);
    step(1, 0, 0, 0, 0, 1);
    check("R4 pulse drops", result, 3'b100);
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 1, 0);
    check("R8 sticky mode", result, 3'b110);
    // R2 events ignored while disabled
    step(0, 0, 1, 1, 1, 0);
    check("R2 disabled", result, 3'b000);
    step(1, 0, 0, 0, 0, 0);
    check("R2 state discarded", result, 3'b000);
    // R3 back-to-back expiry
    step(1, 0, 0, 1, 0, 1);
    step(1, 0, 0, 1, 0, 1);
    check("R3 repeat", result, 3'b001);
    step(1, 0, 0, 0, 0, 1);
    check("R3 single cycle", result, 3'b000);

    begin
      logic pm_cur;
      pm_cur = 0;
      for (int i = 0; i < 3000; i++) begin
        logic te, st;
        te = ($urandom_range(99) >= 4);
        st = ($urandom_range(99) < 5);
        if (st) pm_cur = $urandom_range(1);
        step(te, st, $urandom_range(99) < 20, $urandom_range(99) < 15,
             $urandom_range(99) < 6, pm_cur);
      end
    end

    rst_n = 0;
    #1;
    check("R1 async reset", result, 3'b000);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule